// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is the second-operand shifter of a 32-bit load/store RISC datapath. It takes a register value and shifts or rotates it by an amount that comes either from a 5-bit instruction field or from the low byte of another register. Alongside the shifted value it produces a shifter carry-out, defined for every shift type and every amount, which the flag logic uses for logical operations that update flags. A zero amount has special meanings in the instruction form. A logical or arithmetic right shift by zero stands for a shift by 32. A rotate by zero stands for a one-bit rotate through the carry flag.

A second mode builds an immediate operand. The low 8 bits of the operand input are rotated right by twice the 4-bit field above them. Both modes share one barrel rotator, one mask stage and one carry selector. A decode stage turns the request into a rotate amount, a mask, a fill bit and a carry source. The outputs pass through an optional register, which the parameter `REG_OUT` selects. It is enabled by default and has a synchronous active-low reset.

Top module: `opshift_unit`

## Requirements
- R1: The shift type encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For an amount n from 1 to 31, in either form, the result is the operand shifted or rotated by n. Arithmetic right fills the vacated bits with bit 31.
- R2: A zero amount leaves the operand unchanged and passes `carry_in` to `carry_out` in two cases: a logical left shift in either form, and any shift type in the register form.
- R3: For an amount n from 1 to 31, `carry_out` is the last bit shifted out. That is bit 32-n for a left shift, and bit n-1 for right shifts and rotates.
- R4: An instruction-form rotate by zero rotates right by one through the carry. The result is {carry_in, operand[31:1]} and `carry_out` is operand[0].
- R5: An instruction-form logical right shift by zero gives a zero result, and `carry_out` is operand[31].
- R6: An arithmetic right shift by zero in the instruction form, or by 32 to 255 in the register form, fills every result bit with operand[31]. `carry_out` also equals operand[31].
- R7: The register form uses all 8 amount bits. A logical shift by exactly 32 gives zero. `carry_out` is then operand[0] for a left shift and operand[31] for a right shift.
- R8: A register-form logical shift (left or right) by 33 to 255 gives zero, with `carry_out` 0.
- R9: A register-form rotate by a nonzero amount uses the amount modulo 32. When that remainder is zero, the operand is unchanged and `carry_out` is operand[31].
- R10: When `expand_imm` is 1, the result is operand[7:0] rotated right by 2 × operand[11:8]. `carry_out` is `carry_in` when operand[11:8] is zero, and result bit 31 otherwise. `shift_kind`, `shift_amt`, `amt_is_reg` and operand[31:12] have no effect in this mode.
- R11: The instruction form (`amt_is_reg` = 0) uses only `shift_amt[4:0]`. Bits 7:5 have no effect.
- R12: With `REG_OUT` = 1, the outputs show the inputs sampled at the previous rising edge. While `rst_n` is low at an edge, the outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| expand_imm | input | 1 | 1 selects rotated-immediate expansion |
| shift_kind | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 8 | Shift amount; instruction form uses bits 4:0 |
| amt_is_reg | input | 1 | 1 when the amount came from a register |
| carry_in | input | 1 | Current carry flag |
| operand | input | 32 | Value to shift, or the immediate field in expansion mode |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every one of the 256 amount values, for all four shift types, in both amount forms and with both carry-in values. It uses eight operand patterns: all zeros, all ones, sign-only, LSB-only, mixed alternating patterns, and values with differing end bits. The sweep separates a carry taken from the wrong bit position, which the asymmetric patterns expose. It also separates zero-amount meanings that are swapped between the two forms, and amounts above 32 that are wrongly reduced to five bits. The immediate-expansion mode is swept over all 16 rotate fields, with the shift-control inputs held at unrelated values, so any leakage of those inputs shows up. A reset check and a check that the output holds while the inputs change confirm the one-cycle output register.

// File: rtl/opshift_pkg.sv
// Package: shared encodings for the operand shifter.
// Assumes: shift type encoding is fixed by the instruction decoder.
package opshift_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    // Which bits of the rotated value survive the mask stage
    typedef enum logic [1:0] {
        MK_KEEP     = 2'd0,
        MK_CLR_LOW  = 2'd1,
        MK_CLR_HIGH = 2'd2,
        MK_CLR_ALL  = 2'd3
    } mask_kind_e;

    // Where the carry-out comes from
    typedef enum logic [1:0] {
        CY_HOLD = 2'd0,
        CY_BIT  = 2'd1,
        CY_ZERO = 2'd2
    } carry_src_e;

endpackage

// File: rtl/opshift_decode.sv
// Module: opshift_decode
// Turns a shift type and amount into rotator/mask/carry controls.
// Assumes: DATA_W is a power of two and AMT_W > LOG_W. Instruction-form
// amounts use only the low LOG_W bits; register-form amounts use all AMT_W.
module opshift_decode
    import opshift_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8,
    parameter int unsigned LOG_W  = $clog2(DATA_W)
) (
    input  logic [1:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_amt,
    input  logic             amt_is_reg,
    input  logic             sign_bit,
    input  logic             carry_in,
    output logic [LOG_W-1:0] rot_amt,
    output mask_kind_e       mask_kind,
    output logic [LOG_W-1:0] mask_cnt,
    output logic             fill_bit,
    output carry_src_e       carry_src,
    output logic [LOG_W-1:0] carry_idx
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
    localparam logic [LOG_W-1:0] TOP_IDX  = LOG_W'(DATA_W - 1);
    localparam logic [LOG_W-1:0] ONE_CNT  = LOG_W'(1);

    logic [LOG_W-1:0] cnt_low;
    logic [LOG_W-1:0] neg_cnt;
    logic             amt_zero;
    logic             amt_full;
    logic             amt_beyond;
    logic             amt_ge_full;

    // Classify the amount according to its form
    always_comb begin
        cnt_low     = shift_amt[LOG_W-1:0];
        neg_cnt     = LOG_W'(0) - cnt_low;
        if (amt_is_reg) begin
            amt_zero    = (shift_amt == '0);
            amt_full    = (shift_amt == FULL_AMT);
            amt_beyond  = (shift_amt > FULL_AMT);
            amt_ge_full = (shift_amt >= FULL_AMT);
        end else begin
            amt_zero    = (cnt_low == '0);
            amt_full    = 1'b0;
            amt_beyond  = 1'b0;
            amt_ge_full = 1'b0;
        end
    end

    // Select rotator, mask, fill and carry controls per shift type
    always_comb begin
        rot_amt   = '0;
        mask_kind = MK_KEEP;
        mask_cnt  = '0;
        fill_bit  = 1'b0;
        carry_src = CY_HOLD;
        carry_idx = '0;
        unique case (shift_kind_e'(shift_kind))
            SH_LSL: begin
                if (amt_zero) begin
                    carry_src = CY_HOLD;
                end else if (amt_full) begin
                    mask_kind = MK_CLR_ALL;
                    carry_src = CY_BIT;
                    carry_idx = '0;
                end else if (amt_beyond) begin
                    mask_kind = MK_CLR_ALL;
                    carry_src = CY_ZERO;
                end else begin
                    rot_amt   = neg_cnt;
                    mask_kind = MK_CLR_LOW;
                    mask_cnt  = cnt_low;
                    carry_src = CY_BIT;
                    carry_idx = neg_cnt;
                end
            end
            SH_LSR: begin
                if (amt_zero && amt_is_reg) begin
                    carry_src = CY_HOLD;
                end else if (amt_zero || amt_full) begin
                    mask_kind = MK_CLR_ALL;
                    carry_src = CY_BIT;
                    carry_idx = TOP_IDX;
                end else if (amt_beyond) begin
                    mask_kind = MK_CLR_ALL;
                    carry_src = CY_ZERO;
                end else begin
                    rot_amt   = cnt_low;
                    mask_kind = MK_CLR_HIGH;
                    mask_cnt  = cnt_low;
                    carry_src = CY_BIT;
                    carry_idx = cnt_low - ONE_CNT;
                end
            end
            SH_ASR: begin
                if (amt_zero && amt_is_reg) begin
                    carry_src = CY_HOLD;
                end else if (amt_zero || amt_ge_full) begin
                    mask_kind = MK_CLR_ALL;
                    fill_bit  = sign_bit;
                    carry_src = CY_BIT;
                    carry_idx = TOP_IDX;
                end else begin
                    rot_amt   = cnt_low;
                    mask_kind = MK_CLR_HIGH;
                    mask_cnt  = cnt_low;
                    fill_bit  = sign_bit;
                    carry_src = CY_BIT;
                    carry_idx = cnt_low - ONE_CNT;
                end
            end
            default: begin
                if (amt_zero && amt_is_reg) begin
                    carry_src = CY_HOLD;
                end else if (amt_zero) begin
                    // rotate right by one through the carry flag
                    rot_amt   = ONE_CNT;
                    mask_kind = MK_CLR_HIGH;
                    mask_cnt  = ONE_CNT;
                    fill_bit  = carry_in;
                    carry_src = CY_BIT;
                    carry_idx = '0;
                end else if (cnt_low == '0) begin
                    carry_src = CY_BIT;
                    carry_idx = TOP_IDX;
                end else begin
                    rot_amt   = cnt_low;
                    carry_src = CY_BIT;
                    carry_idx = cnt_low - ONE_CNT;
                end
            end
        endcase
    end

endmodule

// File: rtl/opshift_immrot.sv
// Module: opshift_immrot
// Builds the rotator/carry controls for rotated-immediate expansion.
// Assumes: 2 * (2**ROT_W - 1) fits in LOG_W bits.
module opshift_immrot
    import opshift_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 8,
    parameter int unsigned ROT_W  = 4,
    parameter int unsigned LOG_W  = $clog2(DATA_W)
) (
    input  logic [IMM_W+ROT_W-1:0] imm_field,
    output logic [DATA_W-1:0]      imm_value,
    output logic [LOG_W-1:0]       rot_amt,
    output mask_kind_e             mask_kind,
    output carry_src_e             carry_src,
    output logic [LOG_W-1:0]       carry_idx
);

    logic [ROT_W-1:0] rot_field;

    // Split the field and double the rotate count
    always_comb begin
        rot_field = imm_field[IMM_W+ROT_W-1:IMM_W];
        imm_value = DATA_W'(imm_field[IMM_W-1:0]);
        rot_amt   = LOG_W'({rot_field, 1'b0});
        mask_kind = MK_KEEP;
        carry_src = (rot_field == '0) ? CY_HOLD : CY_BIT;
        carry_idx = rot_amt - LOG_W'(1);
    end

endmodule

// File: rtl/opshift_core.sv
// Module: opshift_core
// Barrel rotate-right, then mask with fill, then carry selection.
// Assumes: every shift is expressed as a rotate plus a mask by the decoder.
module opshift_core
    import opshift_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LOG_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_in,
    input  logic [LOG_W-1:0]  rot_amt,
    input  mask_kind_e        mask_kind,
    input  logic [LOG_W-1:0]  mask_cnt,
    input  logic              fill_bit,
    input  carry_src_e        carry_src,
    input  logic [LOG_W-1:0]  carry_idx,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value_out,
    output logic              carry_out
);

    logic [DATA_W-1:0] stage [LOG_W+1];
    logic [DATA_W-1:0] keep_mask;

    assign stage[0] = value_in;

    // One rotate stage per amount bit, each by a power of two
    for (genvar g = 0; g < LOG_W; g++) begin : g_rot
        localparam int unsigned STEP = 1 << g;
        assign stage[g+1] = rot_amt[g]
            ? {stage[g][STEP-1:0], stage[g][DATA_W-1:STEP]}
            : stage[g];
    end

    // Build the mask of bits that keep rotated data
    always_comb begin
        unique case (mask_kind)
            MK_KEEP:     keep_mask = '1;
            MK_CLR_LOW:  keep_mask = {DATA_W{1'b1}} << mask_cnt;
            MK_CLR_HIGH: keep_mask = {DATA_W{1'b1}} >> mask_cnt;
            default:     keep_mask = '0;
        endcase
    end

    // Merge rotated data with fill bits and pick the carry
    always_comb begin
        value_out = (stage[LOG_W] & keep_mask) | ({DATA_W{fill_bit}} & ~keep_mask);
        unique case (carry_src)
            CY_HOLD: carry_out = carry_in;
            CY_BIT:  carry_out = value_in[carry_idx];
            default: carry_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/opshift_unit.sv
// Module: opshift_unit (top)
// Operand shifter with carry-out and rotated-immediate expansion.
// Assumes: DATA_W a power of two; REG_OUT = 1 adds one cycle of latency
// with a synchronous active-low reset; REG_OUT = 0 is purely combinational.
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned AMT_W   = 8,
    parameter int unsigned IMM_W   = 8,
    parameter int unsigned ROT_W   = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expand_imm,
    input  logic [1:0]        shift_kind,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              amt_is_reg,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int unsigned LOG_W = $clog2(DATA_W);
    localparam int unsigned FLD_W = IMM_W + ROT_W;

    logic [LOG_W-1:0]  sh_rot, im_rot, sel_rot;
    mask_kind_e        sh_mask, im_mask, sel_mask;
    logic [LOG_W-1:0]  sh_cnt, sel_cnt;
    logic              sh_fill, sel_fill;
    carry_src_e        sh_csrc, im_csrc, sel_csrc;
    logic [LOG_W-1:0]  sh_cidx, im_cidx, sel_cidx;
    logic [DATA_W-1:0] im_value, core_in, core_out;
    logic              core_cy;

    opshift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W), .LOG_W(LOG_W)) u_decode (
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .amt_is_reg (amt_is_reg),
        .sign_bit   (operand[DATA_W-1]),
        .carry_in   (carry_in),
        .rot_amt    (sh_rot),
        .mask_kind  (sh_mask),
        .mask_cnt   (sh_cnt),
        .fill_bit   (sh_fill),
        .carry_src  (sh_csrc),
        .carry_idx  (sh_cidx)
    );

    opshift_immrot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .LOG_W(LOG_W)) u_immrot (
        .imm_field (operand[FLD_W-1:0]),
        .imm_value (im_value),
        .rot_amt   (im_rot),
        .mask_kind (im_mask),
        .carry_src (im_csrc),
        .carry_idx (im_cidx)
    );

    // Pick shift controls or immediate-expansion controls
    always_comb begin
        if (expand_imm) begin
            core_in  = im_value;
            sel_rot  = im_rot;
            sel_mask = im_mask;
            sel_cnt  = '0;
            sel_fill = 1'b0;
            sel_csrc = im_csrc;
            sel_cidx = im_cidx;
        end else begin
            core_in  = operand;
            sel_rot  = sh_rot;
            sel_mask = sh_mask;
            sel_cnt  = sh_cnt;
            sel_fill = sh_fill;
            sel_csrc = sh_csrc;
            sel_cidx = sh_cidx;
        end
    end

    opshift_core #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_core (
        .value_in  (core_in),
        .rot_amt   (sel_rot),
        .mask_kind (sel_mask),
        .mask_cnt  (sel_cnt),
        .fill_bit  (sel_fill),
        .carry_src (sel_csrc),
        .carry_idx (sel_cidx),
        .carry_in  (carry_in),
        .value_out (core_out),
        .carry_out (core_cy)
    );

    if (REG_OUT) begin : g_reg_out
        logic past_ok;

        // Register the shifter outputs; clear them in reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                carry_out <= 1'b0;
            end else begin
                result    <= core_out;
                carry_out <= core_cy;
            end
        end

        // Marks cycles whose previous edge was out of reset
        always_ff @(posedge clk) begin
            if (!rst_n) past_ok <= 1'b0;
            else        past_ok <= 1'b1;
        end

        p_reset_clear_r12: assert property (@(posedge clk)
            !rst_n |=> (result == '0 && carry_out == 1'b0));

        p_zero_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(!expand_imm && amt_is_reg && shift_amt == '0)
            |-> (result == $past(operand) && carry_out == $past(carry_in)));

        p_rrx_r4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(!expand_imm && !amt_is_reg && shift_kind == 2'd3
                             && shift_amt[LOG_W-1:0] == '0)
            |-> (result == {$past(carry_in), $past(operand[DATA_W-1:1])}
                 && carry_out == $past(operand[0])));

        p_asr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(!expand_imm && amt_is_reg && shift_kind == 2'd2
                             && shift_amt >= AMT_W'(DATA_W))
            |-> (result == {DATA_W{$past(operand[DATA_W-1])}}
                 && carry_out == $past(operand[DATA_W-1])));

        p_logic_beyond_r8: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(!expand_imm && amt_is_reg && !shift_kind[1]
                             && shift_amt > AMT_W'(DATA_W))
            |-> (result == '0 && carry_out == 1'b0));

        p_imm_norot_r10: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(expand_imm && operand[FLD_W-1:IMM_W] == '0)
            |-> (result == DATA_W'($past(operand[IMM_W-1:0]))
                 && carry_out == $past(carry_in)));
    end else begin : g_comb_out
        assign result    = core_out;
        assign carry_out = core_cy;
    end

endmodule

// File: tb/opshift_unit_tb.sv
`timescale 1ns/1ps
module opshift_unit_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          expand_imm = 1'b0;
    logic [1:0]    shift_kind = 2'd0;
    logic [7:0]    shift_amt = 8'd0;
    logic          amt_is_reg = 1'b0;
    logic          carry_in = 1'b0;
    logic [DW-1:0] operand = '0;
    logic [DW-1:0] result;
    logic          carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    opshift_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .expand_imm (expand_imm),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .amt_is_reg (amt_is_reg),
        .carry_in   (carry_in),
        .operand    (operand),
        .result     (result),
        .carry_out  (carry_out)
    );

    // Register-form reference: {carry, value}
    function automatic logic [DW:0] ref_reg(logic [DW-1:0] v, int t, int n, logic c);
        int m;
        if (n == 0) return {c, v};
        case (t)
            0: begin
                if (n < 32) return {v[32-n], v << n};
                if (n == 32) return {v[0], {DW{1'b0}}};
                return '0;
            end
            1: begin
                if (n < 32) return {v[n-1], v >> n};
                if (n == 32) return {v[31], {DW{1'b0}}};
                return '0;
            end
            2: begin
                if (n < 32) return {v[n-1], DW'($signed(v) >>> n)};
                return {v[31], {DW{v[31]}}};
            end
            default: begin
                m = n % 32;
                if (m == 0) return {v[31], v};
                return {v[m-1], (v >> m) | (v << (32 - m))};
            end
        endcase
    endfunction

    function automatic logic [DW:0] ref_any(logic ex, logic [DW-1:0] v, int t,
                                            int amt, logic isreg, logic c);
        int n;
        int r;
        logic [DW-1:0] iv;
        logic [DW-1:0] rr;
        if (ex) begin
            r  = 2 * int'(v[11:8]);
            iv = {24'd0, v[7:0]};
            if (r == 0) return {c, iv};
            rr = (iv >> r) | (iv << (32 - r));
            return {rr[31], rr};
        end
        if (isreg) return ref_reg(v, t, amt, c);
        n = amt % 32;
        if (n == 0) begin
            if (t == 1 || t == 2) return ref_reg(v, t, 32, c);
            if (t == 3) return {v[0], c, v[31:1]};
        end
        return ref_reg(v, t, n, c);
    endfunction

    function automatic string tag_of(logic ex, int t, int amt, logic isreg);
        if (ex) return "R10";
        if (!isreg) begin
            if (amt >= 32) return "R11";
            if (amt == 0) begin
                case (t)
                    0: return "R2";
                    1: return "R5";
                    2: return "R6";
                    default: return "R4";
                endcase
            end
            return "R1/R3";
        end
        if (amt == 0) return "R2";
        if (amt < 32) return "R1/R3";
        if (t == 3) return "R9";
        if (t == 2) return "R6";
        if (amt == 32) return "R7";
        return "R8";
    endfunction

    task automatic compare(string tag, logic [DW:0] exp);
        n_checks++;
        if ({carry_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: got carry=%0b value=%08h, expected carry=%0b value=%08h",
                     tag, carry_out, result, exp[DW], exp[DW-1:0]);
        end
    endtask

    // Drive one request, wait for the registered output, and check it
    task automatic run_one(logic ex, logic [DW-1:0] v, int t, int amt, logic isreg, logic c);
        expand_imm = ex;
        operand    = v;
        shift_kind = 2'(t);
        shift_amt  = 8'(amt);
        amt_is_reg = isreg;
        carry_in   = c;
        @(posedge clk);
        #1;
        compare(tag_of(ex, t, amt, isreg), ref_any(ex, v, t, amt, isreg, c));
    endtask

    logic [DW-1:0] pats [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                               32'h7FFF_FFFE, 32'h1234_5678, 32'h8000_0000,
                               32'h0000_0001, 32'hA5C3_0F96};

    initial begin
        // R12: reset clears the outputs even with live inputs
        operand  = '1;
        carry_in = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        compare("R12", {1'b0, {DW{1'b0}}});
        rst_n = 1'b1;

        // R1..R9, R11: every amount, type, form and carry value
        for (int p = 0; p < 8; p++)
            for (int t = 0; t < 4; t++)
                for (int f = 0; f < 2; f++)
                    for (int a = 0; a < 256; a++)
                        run_one(1'b0, pats[p], t, a, f[0], a[0] ^ p[0]);

        // R10: immediate expansion; shift controls held at unrelated values
        for (int p = 0; p < 8; p++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 2; c++)
                    run_one(1'b1, {pats[p][31:12], 4'(r), pats[p][7:0]},
                            (p + r) % 4, 37 + r * 13, c[0], c[0]);

        // R12: output holds until the next edge
        run_one(1'b0, 32'h1234_5678, 0, 4, 1'b1, 1'b0);
        operand = 32'hFFFF_FFFF;
        #5;
        compare("R12", {1'b1, 32'h2345_6780});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule